// File: doc/BRIEF.md
# Stop-Mode Wakeup Recovery Sequencer

This block decides when a small processor core may start running again after a stop instruction has halted it. While the core is stopped, the block withholds the core clock enable. The oscillator tick keeps arriving. The block watches two wakeup sources: an active-low reset and an active-low external interrupt pin. The interrupt pin is passed through a synchronizer. A static mode input chooses whether the pin wakes the block only on a falling edge, or also while it is held low.

Once a wakeup is accepted, the block counts a fixed number of oscillator ticks so that the oscillator can settle. The core clock stays gated during this count. When the count completes, the block gives the core its clock back and presents the vector fetch on its own outputs. It shows the high-byte vector address on several consecutive ticks, then the low-byte address on one tick. After that it returns to normal running. A flag reports whether the last wakeup came from reset or from the interrupt pin.

Top module: `stop_wake_seq`

## Requirements
- R1: While the block is stopped or counting the settling delay, `core_clk_en` is 0. In the running and fetch phases, `core_clk_en` equals `osc_tick`.
- R2: A one-cycle `stop_req` pulse in the running phase moves the block to the stopped phase. From the next cycle on, `core_clk_en` is 0, and it stays 0 until a wakeup.
- R3: After an accepted wakeup, the delay is exactly 4064 `osc_tick` pulses. The 12-bit counter behind it is cleared on every stop entry. With a tick on every cycle, the first `vec_fetch` is seen 4067 rising clock edges after a falling edge at `irq_pin_n`. This count includes the two-stage synchronizer and the edge register.
- R4: The fetch phase holds `vec_fetch` at 1. It presents `vec_addr` = 0x1FFE on three consecutive ticks and then 0x1FFF on one tick, and then returns to running. Outside the fetch phase, `vec_addr` is 0.
- R5: With `irq_level_en` = 0, only a falling edge at `irq_pin_n` wakes the block. A pin already held low when stop is entered causes no wakeup.
- R6: With `irq_level_en` = 1, a low level at `irq_pin_n` wakes the block as well. If the pin is held low, a `stop_req` pulse leads to the first `vec_fetch` after 4066 edges.
- R7: While `rst_n` is low, all outputs are idle (`core_clk_en`, `vec_fetch` and `vec_addr` are 0) and `wake_src` is 1. After `rst_n` is released, the same delayed fetch follows, and the first `vec_fetch` appears 4066 edges after the release.
- R8: `wake_src` is 0 after an interrupt-pin wakeup and 1 after a reset wakeup. Reset wins when both sources are active together. `wake_src` is stable throughout a fetch.
- R9: A `stop_req` that arrives during the delay or fetch phase is ignored. It does not change the fetch timing, and the block still returns to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous and release is synchronized. Reset also acts as a wakeup source |
| osc_tick | input | 1 | One internal-cycle tick from the oscillator divider |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| irq_level_en | input | 1 | 0: falling edge only; 1: falling edge or low level |
| stop_req | input | 1 | One-cycle strobe from the core when it executes stop |
| core_clk_en | output | 1 | Clock enable for the core |
| vec_fetch | output | 1 | High during the vector fetch phase |
| vec_addr | output | 13 | Vector address during a fetch, 0 otherwise |
| wake_src | output | 1 | 1 if the last wakeup came from reset, 0 if it came from the interrupt pin |

## Verification
The checker assumes three things about the inputs:
- `irq_level_en` does not change while the block is stopped.
- `stop_req` comes from the running core as a single-cycle strobe.
- `osc_tick` is a clean enable that is synchronous to `clk`.

The stimulus changes `irq_level_en` only while the block is running. It drives `stop_req` for exactly one cycle at a negative edge. It generates the tick from the bench clock, either on every cycle or on every second cycle. The interrupt pin is the one input treated as truly asynchronous. It is driven at arbitrary negative edges, and the checks count the synchronizer latency into the expected fetch edge.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_DELAY = 2'd2,
    ST_FETCH = 2'd3
  } wk_state_e;

  typedef enum logic {
    SRC_IRQ   = 1'b0,
    SRC_RESET = 1'b1
  } wk_src_e;

endpackage

// File: rtl/stop_wake_rst_sync.sv
module stop_wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s = chain_q[STAGES-1];

endmodule

// File: rtl/stop_wake_irq_det.sv
module stop_wake_irq_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_s,
  input  logic pin_n,
  input  logic level_en,
  output logic wake
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   fall;
  logic                   low;

  // Pin idles high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;
  assign low   = ~pin_s;

  generate
    if (SYNC_STAGES > 1) begin : g_sens
      always_comb begin
        wake = fall | (level_en & low);
      end
    end
  endgenerate

endmodule

// File: rtl/stop_wake_timer.sv
module stop_wake_timer #(
  parameter int LIMIT = 4064,
  parameter int CNT_W = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_s,
  input  logic clr,
  input  logic run,
  output logic done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = run & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || done) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int              STAB_CYCLES = 4064,
  parameter int              HI_CYCLES   = 3,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 13,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 13'h1FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              irq_pin_n,
  input  logic              irq_level_en,
  input  logic              stop_req,
  output logic              core_clk_en,
  output logic              vec_fetch,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              wake_src
);

  localparam int              CNT_W   = $clog2(STAB_CYCLES);
  localparam int              FS_W    = $clog2(HI_CYCLES + 1);
  localparam logic [FS_W-1:0] FS_LAST = FS_W'(HI_CYCLES);

  logic            rst_s;
  logic            irq_wake;
  logic            tmr_clr;
  logic            tmr_run;
  logic            tmr_done;
  wk_state_e       state_q, state_d;
  wk_src_e         src_q, src_d;
  logic [FS_W-1:0] fstep_q, fstep_d;

  stop_wake_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  stop_wake_irq_det #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk      (clk),
    .rst_s    (rst_s),
    .pin_n    (irq_pin_n),
    .level_en (irq_level_en),
    .wake     (irq_wake)
  );

  stop_wake_timer #(.LIMIT(STAB_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_s (rst_s),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  // Every stop entry restarts the settling count from zero
  assign tmr_clr = (state_q == ST_RUN) && stop_req;
  assign tmr_run = (state_q == ST_DELAY) && osc_tick;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    fstep_d = fstep_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (irq_wake) begin
          state_d = ST_DELAY;
          src_d   = SRC_IRQ;
        end
      end
      ST_DELAY: begin
        // a stop request here is a recovery in progress and is dropped
        if (tmr_done) begin
          state_d = ST_FETCH;
          fstep_d = '0;
        end
      end
      ST_FETCH: begin
        if (osc_tick) begin
          if (fstep_q == FS_LAST) begin
            state_d = ST_RUN;
            fstep_d = '0;
          end else begin
            fstep_d = fstep_q + 1'b1;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  // Reset is asynchronous, so it always overrides a same-cycle pin wakeup
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_DELAY;
      src_q   <= SRC_RESET;
      fstep_q <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      fstep_q <= fstep_d;
    end
  end

  assign core_clk_en = osc_tick && ((state_q == ST_RUN) || (state_q == ST_FETCH));
  assign vec_fetch   = (state_q == ST_FETCH);
  assign wake_src    = (src_q == SRC_RESET);

  always_comb begin
    vec_addr = '0;
    if (state_q == ST_FETCH) begin
      vec_addr = (fstep_q == FS_LAST) ? (VEC_BASE + 1'b1) : VEC_BASE;
    end
  end

endmodule

// File: rtl/stop_wake_seq_chk.sv
module stop_wake_seq_chk
  import stop_wake_pkg::*;
#(
  parameter int                STAB_CYCLES = 4064,
  parameter int                ADDR_W      = 13,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 13'h1FFE
) (
  input logic              clk,
  input logic              rst_s,
  input logic              osc_tick,
  input logic              stop_req,
  input logic              core_clk_en,
  input logic              vec_fetch,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              wake_src,
  input wk_state_e         st
);

  localparam int CW = $clog2(STAB_CYCLES + 1) + 1;

  logic [CW-1:0] ck_cnt;

  // counts ticks spent in the delay phase, independent of the timer block
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ck_cnt <= '0;
    end else if (st != ST_DELAY) begin
      ck_cnt <= '0;
    end else if (osc_tick) begin
      ck_cnt <= ck_cnt + 1'b1;
    end
  end

  AST_GATED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_STOP || st == ST_DELAY) |-> !core_clk_en);                      // R1
  AST_FULL_DELAY: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(vec_fetch) |-> (ck_cnt == CW'(STAB_CYCLES)));                      // R3
  AST_FETCH_STARTS_HI: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(vec_fetch) |-> (vec_addr == VEC_BASE));                            // R4
  AST_LO_ENDS_FETCH: assert property (@(posedge clk) disable iff (!rst_s)
    (vec_fetch && osc_tick && vec_addr == VEC_BASE + 1'b1) |=> !vec_fetch);  // R4
  AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    !vec_fetch |-> (vec_addr == '0));                                        // R4
  AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_s)
    (vec_fetch && $past(vec_fetch)) |-> $stable(wake_src));                  // R8
  AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_s)
    (stop_req && (st == ST_DELAY || st == ST_FETCH)) |=> (st != ST_STOP));   // R9

endmodule

bind stop_wake_seq stop_wake_seq_chk #(
  .STAB_CYCLES (STAB_CYCLES),
  .ADDR_W      (ADDR_W),
  .VEC_BASE    (VEC_BASE)
) chk_i (
  .clk         (clk),
  .rst_s       (rst_s),
  .osc_tick    (osc_tick),
  .stop_req    (stop_req),
  .core_clk_en (core_clk_en),
  .vec_fetch   (vec_fetch),
  .vec_addr    (vec_addr),
  .wake_src    (wake_src),
  .st          (state_q)
);

// File: tb/stop_wake_seq_tb_top.sv
module stop_wake_seq_tb_top;

  typedef struct packed {
    logic [12:0] addr;
    logic        src;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_tick;
  logic        irq_pin_n;
  logic        irq_level_en;
  logic        stop_req;
  logic        core_clk_en;
  logic        vec_fetch;
  logic [12:0] vec_addr;
  logic        wake_src;
  logic        tick_half = 1'b0;

  int n_cmp  = 0;
  int n_miss = 0;
  bit done   = 1'b0;
  exp_item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  // tick source: every cycle, or every second cycle
  always @(posedge clk) osc_tick <= tick_half ? ~osc_tick : 1'b1;

  stop_wake_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_tick     (osc_tick),
    .irq_pin_n    (irq_pin_n),
    .irq_level_en (irq_level_en),
    .stop_req     (stop_req),
    .core_clk_en  (core_clk_en),
    .vec_fetch    (vec_fetch),
    .vec_addr     (vec_addr),
    .wake_src     (wake_src)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_fetch(input logic src);  // R4 R8 expected sequence
    for (int i = 0; i < 3; i++) q.push_back('{addr: 13'h1FFE, src: src});
    q.push_back('{addr: 13'h1FFF, src: src});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_fetch && osc_tick) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected fetch", int'(vec_addr), 0);
      end else begin
        exp_item_t e;
        e = q.pop_front();
        check(vec_addr == e.addr, "R4 vector address", int'(vec_addr), int'(e.addr));
        check(wake_src == e.src, "R8 wake source", int'(wake_src), int'(e.src));
      end
    end
  end

  // counts edges until vec_fetch; optionally pulses stop_req at edge 'inject'
  task automatic measure(output int n, input int inject);
    n = 0;
    while (!vec_fetch) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      stop_req = (n == inject);
      if (n > 20000) break;
    end
    stop_req = 1'b0;
  endtask

  task automatic drain();
    int g = 0;
    while (q.size() != 0 && g < 20000) begin
      @(negedge clk);
      g++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  initial begin
    int n;
    int bad;
    rst_n = 1'b0; irq_pin_n = 1'b1; irq_level_en = 1'b0; stop_req = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!core_clk_en && !vec_fetch && vec_addr == 0, "R7 idle outputs in reset",
          int'({core_clk_en, vec_fetch}), 0);
    check(wake_src == 1'b1, "R7 wake_src in reset", int'(wake_src), 1);
    rst_n = 1'b1;
    push_fetch(1'b1);
    measure(n, -1);
    check(n == 4066, "R7 R3 reset release to fetch", n, 4066);
    drain();
    check(core_clk_en == 1'b1, "R1 clock enabled when running", int'(core_clk_en), 1);

    // R2 stop entry, R1 gated
    pulse_stop();
    bad = 0;
    repeat (50) begin
      if (core_clk_en || vec_fetch) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2 R1 gated while stopped", bad, 0);

    // R3 edge wakeup latency, R8 source
    irq_pin_n = 1'b0;
    push_fetch(1'b0);
    measure(n, -1);
    check(n == 4067, "R3 pin edge to fetch", n, 4067);
    drain();
    irq_pin_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 edge-only: held-low pin does not wake
    irq_pin_n = 1'b0;
    repeat (10) @(negedge clk);
    pulse_stop();
    bad = 0;
    repeat (200) begin
      if (core_clk_en || vec_fetch) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5 held low ignored in edge mode", bad, 0);
    irq_pin_n = 1'b1;
    repeat (5) @(negedge clk);
    irq_pin_n = 1'b0;
    push_fetch(1'b0);
    measure(n, -1);
    check(n == 4067, "R5 fresh edge wakes", n, 4067);
    drain();

    // R6 level mode with pin held low
    irq_level_en = 1'b1;
    repeat (3) @(negedge clk);
    stop_req = 1'b1;
    push_fetch(1'b0);
    measure(n, -1);
    check(n == 4066, "R6 level wake latency", n, 4066);
    drain();
    irq_level_en = 1'b0;
    irq_pin_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 stop during delay and during fetch is ignored
    pulse_stop();
    repeat (5) @(negedge clk);
    irq_pin_n = 1'b0;
    push_fetch(1'b0);
    measure(n, 100);
    check(n == 4067, "R9 stop in delay ignored", n, 4067);
    pulse_stop();
    drain();
    check(core_clk_en == 1'b1, "R9 stop in fetch ignored", int'(core_clk_en), 1);
    irq_pin_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 R8 reset while stopped
    pulse_stop();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_fetch(1'b1);
    measure(n, -1);
    check(n == 4066, "R7 reset wakes from stop", n, 4066);
    drain();

    // R8 reset and pin together: reset wins
    pulse_stop();
    repeat (10) @(negedge clk);
    rst_n = 1'b0; irq_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_fetch(1'b1);
    measure(n, -1);
    drain();
    check(wake_src == 1'b1, "R8 reset priority", int'(wake_src), 1);
    irq_pin_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R4 half-rate tick
    tick_half = 1'b1;
    repeat (4) @(negedge clk);
    bad = 0;
    repeat (8) begin
      if (core_clk_en != osc_tick) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R1 enable follows tick", bad, 0);
    pulse_stop();
    repeat (4) @(negedge clk);
    irq_pin_n = 1'b0;
    push_fetch(1'b0);
    measure(n, -1);
    drain();
    check(q.size() == 0, "R4 half-rate sequence drained", q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_miss++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
    end
  end

endmodule